// File: doc/BRIEF.md
# E1 Frame Alignment Synchronizer

This block takes a serial E1 NRZ bit stream, one bit per rising edge of its bit clock, and finds the basic frame alignment. A frame is 256 bits long: 32 time slots of 8 bits, and time slot 0 comes first. The 7-bit alignment word occupies bits 2 to 8 of time slot 0 in every other frame. The frames between them carry a 1 in bit 2 of time slot 0. While the block is hunting, it checks every bit position for the word. A candidate position becomes alignment only after three frames in a row give the expected results. Once aligned, the block follows the frame, marks each frame start with a pulse and reports the time slot and bit position of every received bit.

While aligned, the block checks every expected alignment word. Three errored words in a row drop alignment and restart the hunt. Each errored word also goes into a 16-bit error count, except while the loss-of-signal input is high. The running count is copied into the readable output register on a periodic boundary and then restarts. A control input chooses the period: one second, or 62.5 ms. The period lengths are parameters counted in frames, so a bench can shorten them.

Top module: `e1fa_sync`

## Requirements
- R1: While aligned, `ts_cnt` and `bit_cnt` give the time slot (0..31) and the bit position (0..7, first received bit = 0) of the bit sampled at the latest clock edge. They advance by one bit per edge and wrap from slot 31 bit 7 to slot 0 bit 0.
- R2: The alignment word is 0011011, received in time order in bits 2..8 (positions 1..7) of time slot 0. Bit 1 is not examined. Alignment is declared at the edge that samples bit 8 of frame N+2, provided that frame N carried the word, frame N+1 carried a 1 in bit 2 of time slot 0, and frame N+2 carried the word again.
- R3: `searching` is 1 from reset until alignment is declared, and 0 while the block is aligned.
- R4: While aligned, the block checks the word in every other frame. Three consecutive errored words drop alignment at the edge that samples bit 8 of the third one, and the R2 search starts again. One or two errored words in a row leave alignment in place.
- R5: If the frame after a candidate carries a 0 in bit 2 of time slot 0, or if the frame after that does not carry the word, the candidate is abandoned and the block keeps `searching` at 1.
- R6: `frame_sync` is 1 for exactly one cycle, the cycle after the first bit of each frame has been sampled, and only while the block is aligned. It is 0 while the block is searching.
- R7: An errored word counts only while the block is aligned and `los` is 0. Nothing is counted while the block is searching.
- R8: A period boundary falls at the first edge where the edges elapsed since the last boundary (or since the third rising edge after `rst_n` rises) reach P. P is FRAMES_SHORT*256 when `period_short` is 1 and FRAMES_LONG*256 when it is 0. At a boundary, `err_count` takes the running count, including an error found at that same edge, and the running count restarts at 0. Between boundaries `err_count` holds its value.
- R9: The running count is 16 bits wide. It has no saturation logic, because at most 4000 words arrive per second.
- R10: During reset, `searching` is 1, `frame_sync` is 0 and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial NRZ received data |
| los | input | 1 | Loss of signal, blocks error counting while high |
| period_short | input | 1 | 1 selects the 62.5 ms latch period, 0 selects one second |
| frame_sync | output | 1 | One-cycle frame start marker while aligned |
| searching | output | 1 | 1 while hunting for alignment |
| ts_cnt | output | 5 | Time slot of the latest received bit |
| bit_cnt | output | 3 | Bit position of the latest received bit |
| err_count | output | 16 | Latched alignment-word error count |

## Verification
The two functions that can land on the same clock edge are the detection of an errored alignment word and the periodic latch boundary. The bench puts a 504-bit prefix in front of the first frame. Bit 8 of every alignment frame is then sampled on an edge that is a multiple of 256, so with short and long periods of 4 and 12 frames, boundaries coincide with alignment words, and some of those words are deliberately corrupted. For that edge, the expected result is that the latched value includes the colliding error and that the following period starts from zero. Both are checked by comparing `err_count` against the bench model on every cycle.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  localparam int SLOT_BITS  = 8;
  localparam int SLOTS      = 32;
  localparam int FRAME_BITS = SLOT_BITS * SLOTS;
  localparam int BIT_W      = $clog2(SLOT_BITS);
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int POS_W      = BIT_W + SLOT_W;
  localparam int FAW_LEN    = 7;
  localparam logic [FAW_LEN-1:0] FAW_WORD = 7'b0011011;
  // position of bit 8 of slot 0, the last bit of the alignment word
  localparam int CHECK_POS  = SLOT_BITS - 1;

  typedef enum logic [1:0] {
    ST_HUNT     = 2'd0,
    ST_VFY_NFAS = 2'd1,
    ST_VFY_FAS  = 2'd2,
    ST_LOCKED   = 2'd3
  } sync_state_t;
endpackage

// File: rtl/e1fa_rst_sync.sv
module e1fa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/e1fa_bit_window.sv
module e1fa_bit_window #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         rx_bit,
  output logic [W-1:0] window
);
  logic [W-2:0] hist_q;
  logic [W-2:0] hist_d;

  always_comb hist_d = {hist_q[W-3:0], rx_bit};

  // reset to ones: the word starts with two zeros, so no false match
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) hist_q <= '1;
    else         hist_q <= hist_d;
  end

  // oldest bit on the left, bit being sampled now on the right
  assign window = {hist_q, rx_bit};
endmodule

// File: rtl/e1fa_align_ctrl.sv
module e1fa_align_ctrl
  import e1fa_pkg::*;
#(
  parameter int LOSS_THRESH = 3
) (
  input  logic               clk,
  input  logic               rst_ns,
  input  logic [FAW_LEN-1:0] window,
  output logic               locked,
  output logic [POS_W-1:0]   pos,
  output logic               err_word
);
  localparam int MISS_W = $clog2(LOSS_THRESH + 1);

  sync_state_t       state_q, state_d;
  logic [POS_W-1:0]  pos_q, pos_d, pos_inc;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              expf_q, expf_d;
  logic              check, fas_ok, naf_ok;

  always_comb begin
    pos_inc  = pos_q + POS_W'(1);
    check    = (pos_inc == POS_W'(CHECK_POS));
    fas_ok   = (window == FAW_WORD);
    naf_ok   = window[FAW_LEN-1];
    pos_d    = pos_inc;
    state_d  = state_q;
    miss_d   = miss_q;
    expf_d   = expf_q;
    err_word = 1'b0;
    case (state_q)
      ST_HUNT: begin
        if (fas_ok) begin
          pos_d   = POS_W'(CHECK_POS);
          state_d = ST_VFY_NFAS;
        end
      end
      ST_VFY_NFAS: begin
        if (check) state_d = naf_ok ? ST_VFY_FAS : ST_HUNT;
      end
      ST_VFY_FAS: begin
        if (check) begin
          if (fas_ok) begin
            state_d = ST_LOCKED;
            expf_d  = 1'b0;
            miss_d  = '0;
          end else begin
            state_d = ST_HUNT;
          end
        end
      end
      default: begin
        if (check) begin
          expf_d = ~expf_q;
          if (expf_q) begin
            if (fas_ok) begin
              miss_d = '0;
            end else begin
              err_word = 1'b1;
              if (miss_q == MISS_W'(LOSS_THRESH - 1)) begin
                state_d = ST_HUNT;
                miss_d  = '0;
              end else begin
                miss_d = miss_q + MISS_W'(1);
              end
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      miss_q  <= '0;
      expf_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      miss_q  <= miss_d;
      expf_q  <= expf_d;
    end
  end

  assign locked = (state_q == ST_LOCKED);
  assign pos    = pos_q;

  AST_LOCK_VIA_VERIFY: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(state_q == ST_LOCKED) |-> $past(state_q) == ST_VFY_FAS); // R2
  AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ns)
    (locked && $past(locked)) |-> pos_q == $past(pos_q) + POS_W'(1)); // R1
  AST_LOSS_AFTER_MISSES: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(state_q == ST_LOCKED) |-> $past(miss_q) == MISS_W'(LOSS_THRESH - 1)); // R4
endmodule

// File: rtl/e1fa_err_count.sv
module e1fa_err_count
  import e1fa_pkg::*;
#(
  parameter int FRAMES_LONG  = 8000,
  parameter int FRAMES_SHORT = 500,
  parameter int ERR_W        = 16
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             err_word,
  input  logic             los,
  input  logic             period_short,
  output logic [ERR_W-1:0] held
);
  localparam int LONG_BITS  = FRAMES_LONG * FRAME_BITS;
  localparam int SHORT_BITS = FRAMES_SHORT * FRAME_BITS;
  localparam int TMR_W      = $clog2(LONG_BITS);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [TMR_W:0]   lim;
  logic [ERR_W-1:0] live_q, live_d, held_q, held_d, live_inc;
  logic             tick, inc;

  always_comb begin
    lim      = period_short ? (TMR_W+1)'(SHORT_BITS) : (TMR_W+1)'(LONG_BITS);
    tick     = ({1'b0, tmr_q} >= (lim - (TMR_W+1)'(1)));
    inc      = err_word & ~los;
    live_inc = live_q + ERR_W'(inc);
    tmr_d    = tick ? '0 : tmr_q + TMR_W'(1);
    live_d   = tick ? '0 : live_inc;
    held_d   = tick ? live_inc : held_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      tmr_q  <= '0;
      live_q <= '0;
      held_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      live_q <= live_d;
      held_q <= held_d;
    end
  end

  assign held = held_q;

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_ns)
    !tick |=> $stable(held_q)); // R8
  AST_LOS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ns)
    (los && !tick) |=> $stable(live_q)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ns)
    live_q != '1); // R9
endmodule

// File: rtl/e1fa_sync.sv
module e1fa_sync
  import e1fa_pkg::*;
#(
  parameter int FRAMES_LONG  = 8000,
  parameter int FRAMES_SHORT = 500,
  parameter int LOSS_THRESH  = 3,
  parameter int ERR_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              los,
  input  logic              period_short,
  output logic              frame_sync,
  output logic              searching,
  output logic [SLOT_W-1:0] ts_cnt,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic [ERR_W-1:0]  err_count
);
  logic               rst_ns;
  logic [FAW_LEN-1:0] window;
  logic               locked;
  logic [POS_W-1:0]   pos;
  logic               err_word;

  e1fa_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  e1fa_bit_window #(.W(FAW_LEN)) u_win (
    .clk(clk), .rst_ns(rst_ns), .rx_bit(rx_bit), .window(window));

  e1fa_align_ctrl #(.LOSS_THRESH(LOSS_THRESH)) u_align (
    .clk(clk), .rst_ns(rst_ns), .window(window),
    .locked(locked), .pos(pos), .err_word(err_word));

  e1fa_err_count #(.FRAMES_LONG(FRAMES_LONG), .FRAMES_SHORT(FRAMES_SHORT),
                   .ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_ns(rst_ns), .err_word(err_word), .los(los),
    .period_short(period_short), .held(err_count));

  assign searching  = ~locked;
  assign frame_sync = locked && (pos == '0);
  assign ts_cnt     = pos[POS_W-1:BIT_W];
  assign bit_cnt    = pos[BIT_W-1:0];

  AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_ns)
    frame_sync |=> !frame_sync); // R6
endmodule

// File: tb/tb_e1fa_sync.sv
module tb_e1fa_sync;
  localparam int FL = 12;
  localparam int FS = 4;

  logic        clk = 1'b0;
  logic        rst_n, rx_bit, los, period_short;
  logic        frame_sync, searching;
  logic [4:0]  ts_cnt;
  logic [2:0]  bit_cnt;
  logic [15:0] err_count;

  e1fa_sync #(.FRAMES_LONG(FL), .FRAMES_SHORT(FS)) dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .los(los),
    .period_short(period_short), .frame_sync(frame_sync),
    .searching(searching), .ts_cnt(ts_cnt), .bit_cnt(bit_cnt),
    .err_count(err_count));

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model: 0 hunt, 1 verify non-align frame, 2 verify align frame, 3 aligned
  int m_state = 0;
  int m_miss  = 0;
  int m_pos   = 0;
  int m_tmr   = 0;
  int m_live  = 0;
  int m_held  = 0;
  int consec  = 0;

  function automatic int period_bits(bit s);
    return (s ? FS : FL) * 256;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    chk("R2/R3/R4/R5 sync status", searching, (m_state != 3) ? 1 : 0);
    chk("R6 frame_sync", frame_sync, (m_state == 3 && m_pos == 0) ? 1 : 0);
    if (m_state == 3) begin
      chk("R1 ts_cnt", ts_cnt, m_pos / 8);
      chk("R1 bit_cnt", bit_cnt, m_pos % 8);
    end
    chk("R7/R8/R9 err_count", err_count, m_held);
  endtask

  task automatic step(bit b, int pos, bit is_check, bit fas_frame, bit good);
    int err;
    @(negedge clk);
    compare_outputs();
    rx_bit = b;
    err = 0;
    if (is_check) begin
      case (m_state)
        0: if (fas_frame && good) m_state = 1;
        1: m_state = (!fas_frame && good) ? 2 : 0;
        2: begin
          if (fas_frame && good) begin m_state = 3; m_miss = 0; end
          else m_state = 0;
        end
        default: begin
          if (fas_frame) begin
            if (good) m_miss = 0;
            else begin
              err = los ? 0 : 1;
              m_miss++;
              if (m_miss == 3) begin m_state = 0; m_miss = 0; end
            end
          end
        end
      endcase
    end
    m_pos = pos;
    if (m_tmr >= period_bits(period_short) - 1) begin
      m_held = (m_live + err) & 16'hFFFF;
      m_live = 0;
      m_tmr  = 0;
    end else begin
      m_live += err;
      m_tmr++;
    end
  endtask

  task automatic send_frame(int f, bit corrupt, bit naf_bad);
    logic [7:0] by;
    bit fas_frame, good;
    fas_frame = (f % 2 == 0);
    if (fas_frame) begin
      by   = corrupt ? 8'b10011010 : 8'b10011011;
      good = !corrupt;
    end else begin
      by   = naf_bad ? 8'b10111111 : 8'b11111111;
      good = !naf_bad;
    end
    for (int i = 0; i < 256; i++) begin
      // payload never holds two adjacent zeros, so the word cannot appear in it
      if (i >= 8 && i % 8 == 0) by = 8'($urandom) | 8'h55;
      step(by[7 - i % 8], i, (i == 7), fas_frame, good);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit corrupt, naf_bad;
    void'($urandom(32'h0000_E1F5));
    rst_n = 1'b0; rx_bit = 1'b1; los = 1'b0; period_short = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset searching", searching, 1);
    chk("R10 reset frame_sync", frame_sync, 0);
    chk("R10 reset err_count", err_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // prefix puts bit 8 of each alignment frame on a multiple-of-256 edge
    for (int i = 0; i < 504; i++) step(1'b1, 0, 1'b0, 1'b0, 1'b0);
    for (int f = 0; f < 400; f++) begin
      corrupt = 0; naf_bad = 0;
      period_short = (f < 300);
      los = (f >= 250 && f < 300);
      if (f % 2 == 0) begin
        // random errors, never three in a row (R4 hold, R7 count, R8 collisions)
        if (((f >= 40 && f < 58) || (f >= 64 && f < 95) || (f >= 250 && f < 296)
             || (f >= 300 && f < 396)) && consec < 2)
          corrupt = ($urandom_range(2) == 0);
        // errors on latch boundaries (f+2 multiple of 4): R8 collision
        if (f == 62 || f == 66) corrupt = 1;
        // three in a row: R4 loss
        if (f == 100 || f == 102 || f == 104) corrupt = 1;
        if (f == 150 || f == 152 || f == 154) corrupt = 1;
        // R5: the second alignment word after a candidate is wrong
        if (f == 158) corrupt = 1;
        if (f == 200 || f == 202 || f == 204) corrupt = 1;
        consec = corrupt ? consec + 1 : 0;
      end else begin
        // R5: the frame after a candidate carries 0 in bit 2
        if (f == 207) naf_bad = 1;
      end
      send_frame(f, corrupt, naf_bad);
    end
    @(negedge clk);
    compare_outputs();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule